// File: doc/BRIEF.md
# Load/Store Memory Access Unit

This block performs the memory side of data-transfer operations for a small processor core. It receives operands that have already been read from the register file and the kind of operation to perform. From these it forms the effective address and enforces natural alignment. For a store it drives a single-cycle memory port with byte-lane strobes. For a load it collects the read word one cycle later, picks out the addressed lanes and widens them to a full 32-bit result for the register file. A misaligned halfword or word access never reaches memory. It raises a one-cycle alignment fault instead.

Two address forms exist. The register form adds a base value and an offset value, wrapping modulo 2^32. The literal form takes the current program counter with its two low bits cleared and adds an 8-bit unsigned immediate scaled by four, so it reaches 0 to 1020 bytes forward in word steps. The block never writes condition flags. Its flag write-enable output exists only so that the surrounding pipeline sees that fact explicitly.

Top module: `ldst_unit`

## Requirements
- R1: `op_kind` codes are 0 word load, 1 byte load zero-extended, 2 halfword load zero-extended, 3 byte load sign-extended, 4 halfword load sign-extended, 5 word store, 6 byte store, 7 halfword store, 8 literal word load. Codes 9 to 15 cause no memory access, no fault and no write-back.
- R2: A store asserts `mem_req` and `mem_we` in the issue cycle. `mem_be` is 0001, 0010, 0100 or 1000 for a byte at offset 0 to 3, 0011 or 1100 for a halfword at offset 0 or 2, and 1111 for a word. `mem_wdata` repeats the low byte four times for a byte store, the low halfword twice for a halfword store, and the full value for a word store. Only the strobed lanes change in memory.
- R3: For register-form operations, `mem_addr` equals `base_val + offs_val` modulo 2^32.
- R4: For the literal load, `mem_addr` equals (`pc_val` with bits [1:0] cleared) plus `lit_imm`×4, modulo 2^32. The access is always word-sized and never faults.
- R5: A halfword access with address bit 0 set, or a word access with either of bits [1:0] set, does not assert `mem_req`. `align_fault` is high for exactly the cycle after issue. Byte accesses never fault.
- R6: Lanes are little-endian: offset k uses bits [8k+7:8k]. A load result appears on `wb_data` with `wb_we` high and `wb_idx` equal to the issued 3-bit `rt_idx`, in the second cycle after issue. Faulting loads produce no write-back.
- R7: `flag_we` is low at all times.
- R8: After reset, `wb_we`, `align_fault`, `mem_req` and `mem_we` are low when no operation is presented.
- R9: Stores never assert `wb_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 4 | Operation code (see R1) |
| rt_idx | input | 3 | Destination register index for loads |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset register value |
| src_val | input | 32 | Store data register value |
| pc_val | input | 32 | Current program counter for the literal form |
| lit_imm | input | 8 | Unsigned word offset for the literal form |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Write byte strobes |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_rdata | input | 32 | Read word, valid the cycle after a read request |
| align_fault | output | 1 | Misaligned access detected, one-cycle pulse |
| wb_we | output | 1 | Load result write-enable |
| wb_idx | output | 3 | Load result register index |
| wb_data | output | 32 | Extended load result |
| flag_we | output | 1 | Condition flag write-enable, always low |

## Verification
The bench builds the unit with its default widths: 32-bit addresses, an 8-bit literal immediate and 3-bit register indices. It backs the unit with a 16-word memory model indexed by address bits [5:2]. At this size every store width can be tried at every byte offset, and so can every load extension. Each halfword and word kind is driven at each misaligned offset, with sign-bit patterns in every lane. The literal immediate is driven at its extremes 0 and 255 and with program counters whose low bits are set. Register-form sums are made to wrap past 2^32.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int WORD_W     = 32;
  localparam int LANE_N     = WORD_W / 8;
  localparam int LANE_IDX_W = $clog2(LANE_N);

  typedef enum logic [3:0] {
    OP_LDW   = 4'd0,
    OP_LDBU  = 4'd1,
    OP_LDHU  = 4'd2,
    OP_LDBS  = 4'd3,
    OP_LDHS  = 4'd4,
    OP_STW   = 4'd5,
    OP_STB   = 4'd6,
    OP_STH   = 4'd7,
    OP_LDLIT = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } size_e;

  typedef struct packed {
    logic  is_load;
    logic  is_store;
    logic  is_lit;
    logic  sgn;
    size_e size;
  } opinfo_t;

  function automatic opinfo_t decode_op(input logic [3:0] code);
    opinfo_t r;
    r = '0;
    r.size = SZ_W;
    case (code)
      OP_LDW:   r.is_load = 1'b1;
      OP_LDBU:  begin r.is_load = 1'b1; r.size = SZ_B; end
      OP_LDHU:  begin r.is_load = 1'b1; r.size = SZ_H; end
      OP_LDBS:  begin r.is_load = 1'b1; r.size = SZ_B; r.sgn = 1'b1; end
      OP_LDHS:  begin r.is_load = 1'b1; r.size = SZ_H; r.sgn = 1'b1; end
      OP_STW:   r.is_store = 1'b1;
      OP_STB:   begin r.is_store = 1'b1; r.size = SZ_B; end
      OP_STH:   begin r.is_store = 1'b1; r.size = SZ_H; end
      OP_LDLIT: begin r.is_load = 1'b1; r.is_lit = 1'b1; end
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  opinfo_t             info_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]   offs_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [IMM_W-1:0]    imm_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                misal_o
);

  localparam int PAD_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] lit_base;
  logic [ADDR_W-1:0] lit_off;
  logic [ADDR_W-1:0] reg_sum;

  // Literal form: word-aligned PC plus scaled immediate.
  assign lit_base = pc_i & ~ADDR_W'(3);
  assign lit_off  = {{PAD_W{1'b0}}, imm_i, 2'b00};
  // Register form: plain modular sum, carry out discarded.
  assign reg_sum  = base_i + offs_i;

  always_comb begin
    addr_o  = info_i.is_lit ? (lit_base + lit_off) : reg_sum;
    misal_o = 1'b0;
    case (info_i.size)
      SZ_H:    misal_o = addr_o[0];
      SZ_W:    misal_o = |addr_o[1:0];
      default: misal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_pkg::*;
(
  input  size_e                  size_i,
  input  logic [LANE_IDX_W-1:0]  lane_i,
  input  logic [WORD_W-1:0]      src_i,
  output logic [LANE_N-1:0]      be_o,
  output logic [WORD_W-1:0]      data_o
);

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    localparam logic                  UPPER = 1'((l / 2) % 2);
    localparam logic [LANE_IDX_W-1:0] LID   = LANE_IDX_W'(l);
    always_comb begin
      case (size_i)
        SZ_B:    be_o[l] = (lane_i == LID);
        SZ_H:    be_o[l] = (lane_i[1] == UPPER);
        default: be_o[l] = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (size_i)
      SZ_B:    data_o = {LANE_N{src_i[7:0]}};
      SZ_H:    data_o = {(LANE_N / 2){src_i[15:0]}};
      default: data_o = src_i;
    endcase
  end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
(
  input  logic                   sgn_i,
  input  size_e                  size_i,
  input  logic [LANE_IDX_W-1:0]  lane_i,
  input  logic [WORD_W-1:0]      rdata_i,
  output logic [WORD_W-1:0]      data_o
);

  logic [7:0]  byte_v;
  logic [15:0] half_v;

  assign byte_v = rdata_i[{lane_i, 3'b000} +: 8];
  assign half_v = lane_i[1] ? rdata_i[31:16] : rdata_i[15:0];

  always_comb begin
    case (size_i)
      SZ_B:    data_o = {{(WORD_W - 8){sgn_i & byte_v[7]}}, byte_v};
      SZ_H:    data_o = {{(WORD_W - 16){sgn_i & half_v[15]}}, half_v};
      default: data_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [3:0]           op_kind,
  input  logic [IDX_W-1:0]     rt_idx,
  input  logic [ADDR_W-1:0]    base_val,
  input  logic [ADDR_W-1:0]    offs_val,
  input  logic [WORD_W-1:0]    src_val,
  input  logic [ADDR_W-1:0]    pc_val,
  input  logic [IMM_W-1:0]     lit_imm,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LANE_N-1:0]    mem_be,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 align_fault,
  output logic                 wb_we,
  output logic [IDX_W-1:0]     wb_idx,
  output logic [WORD_W-1:0]    wb_data,
  output logic                 flag_we
);

  localparam int LW = LANE_IDX_W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Issue stage (combinational toward memory).
  opinfo_t            info;
  logic [ADDR_W-1:0]  ea;
  logic               misal;
  logic               issue;
  logic               acc_ok;
  logic [LANE_N-1:0]  st_be;
  logic [WORD_W-1:0]  st_data;

  assign info = decode_op(op_kind);

  ldst_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .info_i  (info),
    .base_i  (base_val),
    .offs_i  (offs_val),
    .pc_i    (pc_val),
    .imm_i   (lit_imm),
    .addr_o  (ea),
    .misal_o (misal)
  );

  ldst_store_lanes u_st (
    .size_i (info.size),
    .lane_i (ea[LW-1:0]),
    .src_i  (src_val),
    .be_o   (st_be),
    .data_o (st_data)
  );

  assign issue  = op_valid & (info.is_load | info.is_store);
  assign acc_ok = issue & ~misal;

  assign mem_req   = acc_ok;
  assign mem_we    = acc_ok & info.is_store;
  assign mem_addr  = ea;
  assign mem_be    = (acc_ok & info.is_store) ? st_be : '0;
  assign mem_wdata = st_data;

  // Stage 1: load in flight while memory returns data; fault report.
  logic             p1_vld_d, p1_vld_q;
  logic             fault_d, fault_q;
  logic             p1_en;
  logic             p1_sgn_d, p1_sgn_q;
  size_e            p1_size_d, p1_size_q;
  logic [LW-1:0]    p1_lane_d, p1_lane_q;
  logic [IDX_W-1:0] p1_rt_d, p1_rt_q;

  always_comb begin
    p1_vld_d  = acc_ok & info.is_load;
    fault_d   = issue & misal;
    p1_en     = p1_vld_d;
    p1_sgn_d  = info.sgn;
    p1_size_d = info.size;
    p1_lane_d = ea[LW-1:0];
    p1_rt_d   = rt_idx;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      p1_vld_q  <= 1'b0;
      fault_q   <= 1'b0;
      p1_sgn_q  <= 1'b0;
      p1_size_q <= SZ_B;
      p1_lane_q <= '0;
      p1_rt_q   <= '0;
    end else begin
      p1_vld_q <= p1_vld_d;
      fault_q  <= fault_d;
      if (p1_en) begin
        p1_sgn_q  <= p1_sgn_d;
        p1_size_q <= p1_size_d;
        p1_lane_q <= p1_lane_d;
        p1_rt_q   <= p1_rt_d;
      end
    end
  end

  // Stage 2: extended result registered for the register file.
  logic [WORD_W-1:0] ld_data;
  logic              wb_vld_d, wb_vld_q;
  logic              wb_en;
  logic [IDX_W-1:0]  wb_idx_d, wb_idx_q;
  logic [WORD_W-1:0] wb_data_d, wb_data_q;

  ldst_load_extract u_ld (
    .sgn_i   (p1_sgn_q),
    .size_i  (p1_size_q),
    .lane_i  (p1_lane_q),
    .rdata_i (mem_rdata),
    .data_o  (ld_data)
  );

  always_comb begin
    wb_vld_d  = p1_vld_q;
    wb_en     = p1_vld_q;
    wb_idx_d  = p1_rt_q;
    wb_data_d = ld_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wb_vld_q  <= 1'b0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      wb_vld_q <= wb_vld_d;
      if (wb_en) begin
        wb_idx_q  <= wb_idx_d;
        wb_data_q <= wb_data_d;
      end
    end
  end

  assign align_fault = fault_q;
  assign wb_we       = wb_vld_q;
  assign wb_idx      = wb_idx_q;
  assign wb_data     = wb_data_q;
  assign flag_we     = 1'b0;

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              align_fault,
  input logic              wb_we
);

  // R5: a fault report follows an offered operation that did not reach memory.
  a_r5_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> ($past(op_valid) && !$past(mem_req)));

  // R6: a write-back needs a read request two cycles earlier.
  a_r6_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> $past(mem_req && !mem_we, 2));

  // R2: strobes cover one, two or four lanes.
  a_r2_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  // R2: a halfword uses an aligned lane pair.
  a_r2_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_be) == 2) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  // R2: reads carry no strobes.
  a_r2_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_be == 4'b0000));

  // R5: full-word writes go to aligned addresses only.
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));

  // R5: halfword writes go to even addresses only.
  a_r5_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_be) == 2) |-> !mem_addr[0]);

endmodule

bind ldst_unit ldst_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .align_fault (align_fault),
  .wb_we       (wb_we)
);

// File: tb/sim_ldst_unit.sv
module sim_ldst_unit;

  localparam logic [3:0] K_LDW = 4'd0, K_LDBU = 4'd1, K_LDHU = 4'd2, K_LDBS = 4'd3,
                         K_LDHS = 4'd4, K_STW = 4'd5, K_STB = 4'd6, K_STH = 4'd7,
                         K_LIT = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_kind;
  logic [2:0]  rt_idx;
  logic [31:0] base_val, offs_val, src_val, pc_val;
  logic [7:0]  lit_imm;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        align_fault, wb_we, flag_we;
  logic [2:0]  wb_idx;
  logic [31:0] wb_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ldst_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .rt_idx(rt_idx),
    .base_val(base_val), .offs_val(offs_val), .src_val(src_val), .pc_val(pc_val),
    .lit_imm(lit_imm), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .align_fault(align_fault), .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
    .flag_we(flag_we)
  );

  // Memory model: 16 words, registered read.
  logic [31:0] mem [16];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
      end
    end
  end

  // Captured observations of the last operation.
  logic        c_req, c_we, c_fault, c_wbwe;
  logic [31:0] c_addr, c_wdata, c_wbdata;
  logic [3:0]  c_be;
  logic [2:0]  c_wbidx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] k, input logic [2:0] rt, input logic [31:0] b,
                       input logic [31:0] o, input logic [31:0] s, input logic [31:0] p,
                       input logic [7:0] im);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; rt_idx = rt; base_val = b; offs_val = o;
    src_val = s; pc_val = p; lit_imm = im;
    #1;
    c_req = mem_req; c_we = mem_we; c_addr = mem_addr; c_be = mem_be; c_wdata = mem_wdata;
    @(negedge clk);
    op_valid = 1'b0;
    c_fault = align_fault;
    @(negedge clk);
    c_wbwe = wb_we; c_wbidx = wb_idx; c_wbdata = wb_data;
    chk("R7 flag_we", {31'b0, flag_we}, 32'd0);
  endtask

  function automatic logic [31:0] exp_load(input logic [3:0] k, input logic [31:0] w,
                                           input logic [1:0] off);
    logic [31:0] sh, b, h;
    sh = {27'b0, off, 3'b000};
    b = (w >> sh) & 32'h0000_00FF;
    h = (w >> sh) & 32'h0000_FFFF;
    case (k)
      K_LDBU:  return b;
      K_LDBS:  return b[7] ? (b | 32'hFFFF_FF00) : b;
      K_LDHU:  return h;
      K_LDHS:  return h[15] ? (h | 32'hFFFF_0000) : h;
      default: return w;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input logic [3:0] k, input logic [1:0] off);
    case (k)
      K_STB:   return 4'b0001 << off;
      K_STH:   return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [3:0] k, input logic [31:0] s);
    case (k)
      K_STB:   return (s & 32'h0000_00FF) * 32'h0101_0101;
      K_STH:   return (s & 32'h0000_FFFF) * 32'h0001_0001;
      default: return s;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [3:0]  st_kinds [3];
    logic [3:0]  ld_kinds [5];
    logic [3:0]  bad_kinds [5];
    logic [31:0] pcs [3];
    logic [7:0]  imms [4];
    pats[0] = 32'h80FF_7F01; pats[1] = 32'h7F80_01FE; pats[2] = 32'hDEAD_BEEF; pats[3] = 32'h1234_8765;
    st_kinds[0] = K_STB; st_kinds[1] = K_STH; st_kinds[2] = K_STW;
    ld_kinds[0] = K_LDBU; ld_kinds[1] = K_LDBS; ld_kinds[2] = K_LDHU; ld_kinds[3] = K_LDHS; ld_kinds[4] = K_LDW;
    bad_kinds[0] = K_LDW; bad_kinds[1] = K_STW; bad_kinds[2] = K_LDHU; bad_kinds[3] = K_LDHS; bad_kinds[4] = K_STH;
    pcs[0] = 32'h0000_0103; pcs[1] = 32'h0000_0040; pcs[2] = 32'hFFFF_FFFE;
    imms[0] = 8'd0; imms[1] = 8'd1; imms[2] = 8'd7; imms[3] = 8'd255;

    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem_rdata = 32'h0;
    op_valid = 1'b0; op_kind = 4'd0; rt_idx = 3'd0; base_val = 32'd0; offs_val = 32'd0;
    src_val = 32'd0; pc_val = 32'd0; lit_imm = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: idle state after reset.
    chk("R8 wb_we", {31'b0, wb_we}, 32'd0);
    chk("R8 align_fault", {31'b0, align_fault}, 32'd0);
    chk("R8 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R8 mem_we", {31'b0, mem_we}, 32'd0);
    chk("R7 flag_we reset", {31'b0, flag_we}, 32'd0);

    // R2/R3/R9: every store width at every aligned offset, with wrapping sums.
    for (int s = 0; s < 3; s++) begin
      for (int off = 0; off < 4; off++) begin
        logic [1:0]  o2;
        logic [31:0] src, ea, b, o, expw;
        logic [3:0]  be;
        o2 = 2'(off);
        if ((st_kinds[s] == K_STH && off[0]) || (st_kinds[s] == K_STW && off != 0)) continue;
        src = pats[(s + off) % 4];
        ea  = 32'd8 + 32'(off);
        b   = (off % 2 == 1) ? 32'hFFFF_FFF8 : 32'd4;
        o   = ea - b;
        do_op(K_STW, 3'd0, 32'd8, 32'd0, 32'h0, 32'h0, 8'd0);
        do_op(st_kinds[s], 3'd1, b, o, src, 32'h0, 8'd0);
        chk("R3 store addr", c_addr, ea);
        chk("R2 store req/we", {30'b0, c_req, c_we}, 32'd3);
        be = exp_be(st_kinds[s], o2);
        chk("R2 strobes", {28'b0, c_be}, {28'b0, be});
        chk("R2 wdata", c_wdata, exp_wd(st_kinds[s], src));
        chk("R5 byte/aligned no fault", {31'b0, c_fault}, 32'd0);
        chk("R9 store no wb", {31'b0, c_wbwe}, 32'd0);
        expw = 32'h0;
        for (int l = 0; l < 4; l++) if (be[l]) expw[8*l +: 8] = exp_wd(st_kinds[s], src) >> (8*l);
        do_op(K_LDW, 3'd2, 32'd8, 32'd0, 32'h0, 32'h0, 8'd0);
        chk("R2 lanes written", c_wbdata, expw);
      end
    end

    // R1/R6: every load extension at every legal offset over sign-rich patterns.
    for (int p = 0; p < 4; p++) begin
      do_op(K_STW, 3'd0, 32'd16, 32'd4, pats[p], 32'h0, 8'd0);
      for (int off = 0; off < 4; off++) begin
        for (int k = 0; k < 5; k++) begin
          logic [2:0] rt;
          if ((ld_kinds[k] == K_LDHU || ld_kinds[k] == K_LDHS) && off[0]) continue;
          if (ld_kinds[k] == K_LDW && off != 0) continue;
          rt = 3'((off + k + p) % 8);
          do_op(ld_kinds[k], rt, 32'd20 + 32'(off), 32'd0, 32'h0, 32'h0, 8'd0);
          chk("R6 wb_we", {31'b0, c_wbwe}, 32'd1);
          chk("R6 wb_idx", {29'b0, c_wbidx}, {29'b0, rt});
          chk("R1 load value", c_wbdata, exp_load(ld_kinds[k], pats[p], 2'(off)));
          chk("R5 legal no fault", {31'b0, c_fault}, 32'd0);
        end
      end
    end

    // R5: misaligned halfword and word accesses; memory left untouched.
    do_op(K_STW, 3'd0, 32'd28, 32'd0, 32'hA5A5_5A5A, 32'h0, 8'd0);
    for (int k = 0; k < 5; k++) begin
      for (int off = 1; off < 4; off++) begin
        logic is_half;
        is_half = (bad_kinds[k] == K_LDHU || bad_kinds[k] == K_LDHS || bad_kinds[k] == K_STH);
        if (is_half && off == 2) continue;
        do_op(bad_kinds[k], 3'd5, 32'd28, 32'(off), 32'hFFFF_FFFF, 32'h0, 8'd0);
        chk("R5 no mem_req", {31'b0, c_req}, 32'd0);
        chk("R5 fault pulse", {31'b0, c_fault}, 32'd1);
        chk("R5 no wb", {31'b0, c_wbwe}, 32'd0);
        chk("R5 fault one cycle", {31'b0, align_fault}, 32'd0);
      end
    end
    do_op(K_LDW, 3'd4, 32'd28, 32'd0, 32'h0, 32'h0, 8'd0);
    chk("R5 memory untouched", c_wbdata, 32'hA5A5_5A5A);

    // R4: literal loads over PC low bits and immediate extremes.
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] ea;
        ea = (pcs[p] & 32'hFFFF_FFFC) + {22'b0, imms[i], 2'b00};
        do_op(K_LIT, 3'd7, 32'h3, 32'h0, 32'h0, pcs[p], imms[i]);
        chk("R4 literal addr", c_addr, ea);
        chk("R4 literal no fault", {31'b0, c_fault}, 32'd0);
        chk("R4 literal wb_we", {31'b0, c_wbwe}, 32'd1);
        chk("R4 literal data", c_wbdata, mem[ea[5:2]]);
      end
    end

    // R1: unused codes do nothing, even with a misaligned address.
    for (int k = 9; k < 16; k++) begin
      do_op(4'(k), 3'd3, 32'd1, 32'd2, 32'h0, 32'h0, 8'd0);
      chk("R1 unused code req", {31'b0, c_req}, 32'd0);
      chk("R1 unused code fault", {31'b0, c_fault}, 32'd0);
      chk("R1 unused code wb", {31'b0, c_wbwe}, 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule